// File: doc/BRIEF.md
# Status Register with Quarter-Lock Write Guard

This block keeps the eight-bit status byte of a small serial memory and decides, every cycle, whether a status update or an array write may proceed. Its state is a protect-enable bit that arms an external protect pin, a two-bit lock code that closes off the top quarter, the top half or the whole array, a volatile write-enable latch, and a busy flag. The nonvolatile bits are plain flops with a reset value.

A command front-end sends it single-cycle pulses: arm the latch, disarm it, and commit a status update (with its data byte), plus a level that is high for the whole status-update sequence. The block also sees the active-low protect pin, the busy level of the program engine, and the address of the array write under consideration. Its outputs are registered: the status byte as a host would read it, an allow-status-write flag and an allow-array-write flag for the given address. The front-end starts a write only when the matching flag is high. When the busy level falls at the end of any program cycle, the block clears its latch.

Top module: `stat_guard`

## Requirements
- R1: After reset the status byte reads 0x00 and both permission flags are 0. Outside a busy cycle the byte reads bit 7 = protect-enable, bits 6..4 = 0, bits 3..2 = lock code, bit 1 = write-enable latch, bit 0 = 0.
- R2: An arm pulse sets the latch and a disarm pulse clears it, with disarm winning when both come together. Both pulses are ignored while busy is high. The falling edge of busy clears the latch.
- R3: The top two address bits give the quarter q (0..3). Lock code 0 locks no quarter, 1 locks q=3, 2 locks q of 2 or more, and 3 locks every quarter. The array flag is 1 only when the latch is set, busy is low and the quarter is unlocked.
- R4: Hardware protection is on when the pin is low and protect-enable is 1. While it is on, the status flag is 0 and a status commit changes nothing, protect-enable included. The array flag is not affected by it.
- R5: With the latch clear, neither flag is ever 1. With the latch set, busy low and no hardware protection, the status flag is 1.
- R6: While busy is high, the status byte reads 0xFF and both flags are 0.
- R7: An accepted status commit stores data bit 7 as protect-enable and data bits 3..2 as the lock code. The other data bits are dropped.
- R8: If the pin is low with protect-enable set at any cycle of a status-update sequence, that sequence's commit is rejected, even if the pin is high again at commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n_i | input | 1 | Protect pin, active low |
| busy_i | input | 1 | Program cycle in progress |
| pel_set_i | input | 1 | Arm the write-enable latch (pulse) |
| pel_clr_i | input | 1 | Disarm the write-enable latch (pulse) |
| sts_seq_i | input | 1 | High during a status-update sequence |
| sts_commit_i | input | 1 | Commit the status update (pulse) |
| sts_data_i | input | 8 | Status update data |
| addr_i | input | ADDR_W | Array write address under consideration |
| status_o | output | 8 | Status byte as read by the host |
| sts_wr_ok_o | output | 1 | Status write allowed |
| arr_wr_ok_o | output | 1 | Array write allowed at addr_i |

## Verification
The bench builds the block with a four-bit address, so each quarter holds four addresses and a full address sweep is sixteen steps. With this size every address can be checked against every lock code, both protect-enable values, both pin levels and both latch states. The sweep covers each quarter boundary for each lock code. The single-case tests cover the busy overlay, latch clearing on completion, commands ignored while busy, dropped data bits, the self-locking protect-enable bit and the abort of a sequence by a pin pulse.

// File: rtl/stat_guard_pkg.sv
package stat_guard_pkg;

  typedef struct packed {
    logic       prot_en;
    logic [1:0] lock;
    logic       pel;
  } stat_state_t;

  localparam logic [7:0] BUSY_IMAGE = 8'hFF;

  function automatic logic [7:0] stat_image(input stat_state_t s);
    return {s.prot_en, 3'b000, s.lock, s.pel, 1'b0};
  endfunction

endpackage

// File: rtl/stat_lock_decode.sv
module stat_lock_decode #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        lock_i,
  output logic              locked_o
);
  localparam int QTOP = ADDR_W - 1;
  localparam int QBOT = ADDR_W - 2;

  logic [1:0] quarter;
  logic [2:0] first_locked;

  always_comb begin
    quarter = addr_i[QTOP:QBOT];
    unique case (lock_i)
      2'd0:    first_locked = 3'd4;
      2'd1:    first_locked = 3'd3;
      2'd2:    first_locked = 3'd2;
      default: first_locked = 3'd0;
    endcase
    locked_o = ({1'b0, quarter} >= first_locked);
  end
endmodule

// File: rtl/stat_regs.sv
module stat_regs
  import stat_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wp_n_i,
  input  logic        busy_i,
  input  logic        pel_set_i,
  input  logic        pel_clr_i,
  input  logic        sts_seq_i,
  input  logic        sts_commit_i,
  input  logic [7:0]  sts_data_i,
  output stat_state_t state_o,
  output logic        hw_prot_o
);
  stat_state_t st_q;
  logic        busy_d;
  logic        abort_q;
  logic        hw_prot;
  logic        commit_ok;
  logic        done;

  assign hw_prot   = st_q.prot_en && !wp_n_i;
  assign done      = busy_d && !busy_i;
  assign commit_ok = sts_commit_i && st_q.pel && !hw_prot && !busy_i && !abort_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= '0;
      busy_d  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      busy_d <= busy_i;
      if (!sts_seq_i)   abort_q <= 1'b0;
      else if (hw_prot) abort_q <= 1'b1;
      if (commit_ok) begin
        st_q.prot_en <= sts_data_i[7];
        st_q.lock    <= sts_data_i[3:2];
      end
      if (done)                    st_q.pel <= 1'b0;
      else if (!busy_i) begin
        if (pel_clr_i)             st_q.pel <= 1'b0;
        else if (pel_set_i)        st_q.pel <= 1'b1;
      end
    end
  end

  assign state_o   = st_q;
  assign hw_prot_o = hw_prot;

  p_done_clears_latch_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_i) |=> !st_q.pel);

  p_hwp_freezes_status_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q.prot_en && !wp_n_i && sts_commit_i) |=> $stable({st_q.prot_en, st_q.lock}));

  p_busy_holds_latch_r2: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !st_q.pel) |=> !st_q.pel);
endmodule

// File: rtl/stat_guard.sv
module stat_guard
  import stat_guard_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic              pel_set_i,
  input  logic              pel_clr_i,
  input  logic              sts_seq_i,
  input  logic              sts_commit_i,
  input  logic [7:0]        sts_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        status_o,
  output logic              sts_wr_ok_o,
  output logic              arr_wr_ok_o
);
  stat_state_t st;
  logic        hw_prot;
  logic        locked;

  stat_regs i_regs (
    .clk          (clk),
    .rst          (rst),
    .wp_n_i       (wp_n_i),
    .busy_i       (busy_i),
    .pel_set_i    (pel_set_i),
    .pel_clr_i    (pel_clr_i),
    .sts_seq_i    (sts_seq_i),
    .sts_commit_i (sts_commit_i),
    .sts_data_i   (sts_data_i),
    .state_o      (st),
    .hw_prot_o    (hw_prot)
  );

  stat_lock_decode #(.ADDR_W(ADDR_W)) i_lock (
    .addr_i   (addr_i),
    .lock_i   (st.lock),
    .locked_o (locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o    <= 8'h00;
      sts_wr_ok_o <= 1'b0;
      arr_wr_ok_o <= 1'b0;
    end else begin
      status_o    <= busy_i ? BUSY_IMAGE : stat_image(st);
      sts_wr_ok_o <= st.pel && !busy_i && !hw_prot;
      arr_wr_ok_o <= st.pel && !busy_i && !locked;
    end
  end

  p_busy_reads_ones_r6: assert property (@(posedge clk) disable iff (rst)
    status_o[0] |-> (status_o == 8'hFF && !sts_wr_ok_o && !arr_wr_ok_o));

  p_sts_needs_latch_r5: assert property (@(posedge clk) disable iff (rst)
    sts_wr_ok_o |-> status_o[1]);

  p_arr_needs_latch_r5: assert property (@(posedge clk) disable iff (rst)
    arr_wr_ok_o |-> status_o[1]);

  p_full_lock_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (status_o[3:2] == 2'b11 && !status_o[0]) |-> !arr_wr_ok_o);

  p_unused_bits_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !status_o[0] |-> (status_o[6:4] == 3'b000));
endmodule

// File: tb/test_stat_guard.sv
module test_stat_guard;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wp_n_i = 1'b1, busy_i = 1'b0;
  logic          pel_set_i = 1'b0, pel_clr_i = 1'b0;
  logic          sts_seq_i = 1'b0, sts_commit_i = 1'b0;
  logic [7:0]    sts_data_i = 8'h00;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    status_o;
  logic          sts_wr_ok_o, arr_wr_ok_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  stat_guard #(.ADDR_W(AW)) i_stat_guard (
    .clk(clk), .rst(rst), .wp_n_i(wp_n_i), .busy_i(busy_i),
    .pel_set_i(pel_set_i), .pel_clr_i(pel_clr_i),
    .sts_seq_i(sts_seq_i), .sts_commit_i(sts_commit_i),
    .sts_data_i(sts_data_i), .addr_i(addr_i),
    .status_o(status_o), .sts_wr_ok_o(sts_wr_ok_o), .arr_wr_ok_o(arr_wr_ok_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic arm();
    pel_set_i = 1'b1; @(negedge clk); pel_set_i = 1'b0; settle();
  endtask

  task automatic disarm();
    pel_clr_i = 1'b1; @(negedge clk); pel_clr_i = 1'b0; settle();
  endtask

  task automatic busy_cycle();
    busy_i = 1'b1; repeat (3) @(negedge clk); busy_i = 1'b0; settle();
  endtask

  task automatic commit(input logic [7:0] d);
    sts_seq_i = 1'b1; @(negedge clk);
    sts_commit_i = 1'b1; sts_data_i = d; @(negedge clk);
    sts_commit_i = 1'b0; sts_seq_i = 1'b0; settle();
  endtask

  function automatic logic locked(input int lk, input int a);
    int q = a >> (AW - 2);
    int first = (lk == 0) ? 4 : (lk == 1) ? 3 : (lk == 2) ? 2 : 0;
    return q >= first;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset state
    chk("R1 reset status", status_o, 8'h00);
    chk("R1 reset flags", {6'b0, sts_wr_ok_o, arr_wr_ok_o}, 8'h00);

    // R6 busy overlay, R2 completion clears latch
    arm();
    chk("R2 armed", status_o, 8'h02);
    busy_i = 1'b1; settle();
    chk("R6 busy image", status_o, 8'hFF);
    chk("R6 busy flags", {6'b0, sts_wr_ok_o, arr_wr_ok_o}, 8'h00);
    pel_clr_i = 1'b1; @(negedge clk); pel_clr_i = 1'b0;
    busy_i = 1'b0; settle();
    chk("R2 done clears latch", status_o, 8'h00);
    // R2 arm ignored while busy
    busy_i = 1'b1; pel_set_i = 1'b1; @(negedge clk); pel_set_i = 1'b0;
    busy_i = 1'b0; settle();
    chk("R2 arm while busy ignored", status_o, 8'h00);
    // R2 disarm wins
    pel_set_i = 1'b1; pel_clr_i = 1'b1; @(negedge clk);
    pel_set_i = 1'b0; pel_clr_i = 1'b0; settle();
    chk("R2 disarm priority", status_o, 8'h00);

    // R7 dropped bits
    arm(); commit(8'h7B);
    chk("R7 stored bits", status_o, 8'h0A);
    busy_cycle();
    chk("R7 after cycle", status_o, 8'h08);
    // R5 commit without latch ignored
    commit(8'h00);
    chk("R5 no latch no write", status_o, 8'h08);

    // R4 self-locking protect-enable
    arm(); commit(8'h80); busy_cycle();
    chk("R4 prot-en set", status_o, 8'h80);
    wp_n_i = 1'b0; arm();
    chk("R4 status flag off", {7'b0, sts_wr_ok_o}, 8'h00);
    commit(8'h0C);
    chk("R4 commit rejected", status_o, 8'h82);
    // R8 abort by pin pulse during sequence
    wp_n_i = 1'b1; settle();
    chk("R5 status flag on", {7'b0, sts_wr_ok_o}, 8'h01);
    sts_seq_i = 1'b1; @(negedge clk);
    wp_n_i = 1'b0; @(negedge clk); wp_n_i = 1'b1; @(negedge clk);
    sts_commit_i = 1'b1; sts_data_i = 8'h0C; @(negedge clk);
    sts_commit_i = 1'b0; sts_seq_i = 1'b0; settle();
    chk("R8 aborted commit", status_o, 8'h82);
    // next clean sequence succeeds
    commit(8'h00); busy_cycle();
    chk("R8 clean sequence accepted", status_o, 8'h00);

    // Sweep: lock code x prot-en x pin x latch x address
    for (int lk = 0; lk < 4; lk++) begin
      for (int pe = 0; pe < 2; pe++) begin
        wp_n_i = 1'b1;
        arm(); commit({pe[0], 3'b000, lk[1:0], 2'b00}); busy_cycle();
        chk("R7 sweep program", status_o, {pe[0], 3'b000, lk[1:0], 2'b00});
        for (int pin = 0; pin < 2; pin++) begin
          wp_n_i = pin[0]; settle();
          for (int pl = 0; pl < 2; pl++) begin
            if (pl == 1) arm();
            chk("R1 sweep image", status_o, {pe[0], 3'b000, lk[1:0], pl[0], 1'b0});
            chk("R4 status flag", {7'b0, sts_wr_ok_o},
                {7'b0, (pl == 1) && !(pe == 1 && pin == 0)});
            for (int a = 0; a < (1 << AW); a++) begin
              addr_i = a[AW-1:0]; settle();
              chk("R3 array flag", {7'b0, arr_wr_ok_o},
                  {7'b0, (pl == 1) && !locked(lk, a)});
            end
            if (pl == 1) disarm();
          end
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule